// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable single-port burst memory with a registered read path, meant to sit behind a bus master that issues four-beat bursts. An access begins when one of two address strobes is sampled high. The strobe from the processor side always starts a read. The strobe from the controller side starts a read or a write, depending on the write controls sampled in the same cycle. The block keeps the start address and a two-bit beat counter. The counter moves forward only in cycles where the advance input is high. The low two address bits then follow either an incrementing order or an XOR order, chosen by a mode input that is latched with the strobe.

Every synchronous input is registered. The memory array and the output stage are each one further register stage. The first word of a burst therefore appears in the third cycle after the strobe, and each later beat appears one cycle after the one before it. Three chip enables are decoded at strobe time, so several devices can share a bus for depth expansion. Once a device has been deselected, it keeps returning data for two more cycles, which drains its pipeline without a gap. The output enable gates the valid flag and the data combinationally.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0 until a selected read has moved through the pipeline.
- R2: The start address and the chip-enable state are loaded only in a cycle where `strb_proc` or `strb_ctrl` is high. In any other cycle, changes on `addr` have no effect on the word being accessed.
- R3: The beat counter resets to 0 at every strobe. After that it advances by one (modulo 4) only at an edge where `adv` is high; otherwise the same word is accessed again.
- R4: With `burst_ilv` = 0 at strobe time, beat k reads the word whose low two address bits are (start + k) mod 4. The upper address bits stay fixed.
- R5: With `burst_ilv` = 1 at strobe time, beat k reads the word whose low two address bits are start XOR k. The upper address bits stay fixed.
- R6: Read data for a strobe sampled at edge E0 is first valid after edge E0+2 and not before. With `adv` held high, each later beat follows one cycle after the previous one.
- R7: With `oe` low, `rvalid` and `rdata` are 0 in that same cycle. Raising `oe` restores the pending data with no clock edge.
- R8: The device is selected only when `chip_en0` = 1, `chip_en1` = 1 and `chip_dis2` = 0 at strobe time. An unselected access produces no read data and writes nothing.
- R9: When `all_we` = 1 in a write cycle, all four 9-bit lanes are written. Lane i is `wdata[9i+8:9i]`.
- R10: When `all_we` = 0 and `lane_we_en` = 1, only the lanes whose bit in `lane_we` is 1 are written. When both `all_we` and `lane_we_en` are 0, the cycle is a read.
- R11: After a deselecting strobe is sampled at edge Ed, `rvalid` stays high after Ed and after Ed+1, and is low after Ed+2.
- R12: A cycle started by `strb_proc` is a read, and any write controls in that cycle are ignored. A cycle started by `strb_ctrl` alone is a write when the write controls select a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| wdata | input | LANES*LANE_W | Write data, lane i at bits 9i+8..9i |
| chip_en0 | input | 1 | Chip enable, active high |
| chip_en1 | input | 1 | Depth-expansion enable, active high |
| chip_dis2 | input | 1 | Depth-expansion enable, active low |
| strb_proc | input | 1 | Processor-side address strobe (read only) |
| strb_ctrl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Advance the burst counter |
| burst_ilv | input | 1 | 1 = XOR burst order, 0 = incrementing |
| lane_we | input | LANES | Per-lane write enables |
| lane_we_en | input | 1 | Qualifies `lane_we` |
| all_we | input | 1 | Write all lanes |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench uses start addresses 1 and 3, where the incrementing and XOR orders produce different sequences. A design that mixes up the two orders, or that wraps the counter into the upper address bits, returns the wrong words. Each read checks that no data is valid after the first two edges and that data is valid after the third. An off-by-one pipeline shows up as data that is early or late. A deselect is timed so that a single-cycle drain drops `rvalid` one cycle early. Byte-lane merges, writes under a bad chip enable, writes under the processor strobe, and address changes while the strobe is low are each read back afterwards, so any write or reload that leaked through shows up as corrupted data.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_ord_e;

  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input burst_ord_e ord);
    return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/bsram_ctl.sv
module bsram_ctl import bsram_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_en0,
  input  logic              chip_en1,
  input  logic              chip_dis2,
  input  logic              strb_proc,
  input  logic              strb_ctrl,
  input  logic              adv,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  lane_we,
  input  logic              lane_we_en,
  input  logic              all_we,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              acc_sel,
  output logic              acc_wr,
  output logic [LANES-1:0]  acc_lanes
);
  logic              start;
  logic [LANES-1:0]  lanes_req;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  burst_ord_e        ord_q;
  logic              sel_q;
  logic [LANES-1:0]  lanes_q;

  assign start     = strb_proc | strb_ctrl;
  assign lanes_req = strb_proc ? '0 :
                     all_we     ? '1 :
                     lane_we_en ? lane_we : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      cnt_q   <= 2'd0;
      ord_q   <= ORD_LINEAR;
      sel_q   <= 1'b0;
      lanes_q <= '0;
    end else begin
      lanes_q <= lanes_req;
      if (start) begin
        base_q <= addr;
        cnt_q  <= 2'd0;
        ord_q  <= burst_ord_e'(burst_ilv);
        sel_q  <= chip_en0 & chip_en1 & ~chip_dis2;
      end else if (adv) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign cur_addr  = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, ord_q)};
  assign acc_sel   = sel_q;
  assign acc_lanes = lanes_q;
  assign acc_wr    = |lanes_q;

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(base_q)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !adv) |=> $stable(cnt_q)); // R3
  AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
    strb_proc |=> !acc_wr); // R12
  AST_DECODE_OFF: assert property (@(posedge clk) disable iff (rst)
    (start && (!chip_en0 || !chip_en1 || chip_dis2)) |=> !acc_sel); // R8
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/bsram_out.sv
module bsram_out #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_data,
  input  logic         oe,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  logic [W-1:0] dat_q;
  logic         v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      v_q   <= 1'b0;
    end else begin
      dat_q <= in_data;
      v_q   <= in_v;
    end
  end

  assign rvalid = oe & v_q;
  assign rdata  = rvalid ? dat_q : '0;

  AST_PIPE_STEP: assert property (@(posedge clk) disable iff (rst)
    in_v |=> v_q); // R6
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              chip_en0,
  input  logic              chip_en1,
  input  logic              chip_dis2,
  input  logic              strb_proc,
  input  logic              strb_ctrl,
  input  logic              adv,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  lane_we,
  input  logic              lane_we_en,
  input  logic              all_we,
  input  logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [ADDR_W-1:0] cur_addr;
  logic              acc_sel;
  logic              acc_wr;
  logic [LANES-1:0]  acc_lanes;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] arr_rd;
  logic              rd_issue;
  logic              rd_v_q;

  bsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst(rst), .addr(addr),
    .chip_en0(chip_en0), .chip_en1(chip_en1), .chip_dis2(chip_dis2),
    .strb_proc(strb_proc), .strb_ctrl(strb_ctrl), .adv(adv),
    .burst_ilv(burst_ilv), .lane_we(lane_we), .lane_we_en(lane_we_en),
    .all_we(all_we), .cur_addr(cur_addr), .acc_sel(acc_sel),
    .acc_wr(acc_wr), .acc_lanes(acc_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) wd_q <= '0;
    else     wd_q <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk (clk),
      .we  (acc_sel & acc_lanes[g]),
      .addr(cur_addr),
      .wd  (wd_q[g*LANE_W +: LANE_W]),
      .rd  (arr_rd[g*LANE_W +: LANE_W])
    );
  end

  assign rd_issue = acc_sel & ~acc_wr;

  always_ff @(posedge clk) begin
    if (rst) rd_v_q <= 1'b0;
    else     rd_v_q <= rd_issue;
  end

  bsram_out #(.W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_v(rd_v_q), .in_data(arr_rd),
    .oe(oe), .rdata(rdata), .rvalid(rvalid)
  );

  AST_DRAIN_TWO: assert property (@(posedge clk) disable iff (rst)
    rd_issue |=> ##1 (rvalid || !oe)); // R11
  AST_NO_SEL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (!acc_sel && oe) |=> ##1 !rvalid); // R8
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          chip_en0, chip_en1, chip_dis2;
  logic          strb_proc, strb_ctrl, adv, burst_ilv;
  logic [3:0]    lane_we;
  logic          lane_we_en, all_we, oe;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] exp_mem [1 << AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .chip_en0(chip_en0), .chip_en1(chip_en1), .chip_dis2(chip_dis2),
    .strb_proc(strb_proc), .strb_ctrl(strb_ctrl), .adv(adv),
    .burst_ilv(burst_ilv), .lane_we(lane_we), .lane_we_en(lane_we_en),
    .all_we(all_we), .oe(oe), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] s);
    return {a[8:0] ^ {1'b0, s}, ~a[8:0], {1'b1, s}, a[8:0] + 9'd77};
  endfunction

  task automatic idle;
    addr = '0; wdata = '0; chip_en0 = 1; chip_en1 = 1; chip_dis2 = 0;
    strb_proc = 0; strb_ctrl = 0; adv = 0; burst_ilv = 0;
    lane_we = '0; lane_we_en = 0; all_we = 0; oe = 1;
  endtask

  task automatic deselect_drain;
    strb_proc = 1; chip_en0 = 0; adv = 0; all_we = 0; lane_we_en = 0;
    tick;
    strb_proc = 0; chip_en0 = 1;
    tick; tick;
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic all, input logic en, input logic [3:0] lanes);
    addr = a; wdata = d; all_we = all; lane_we_en = en; lane_we = lanes;
    strb_ctrl = 1;
    tick;
    strb_ctrl = 0; all_we = 0; lane_we_en = 0; lane_we = '0;
    deselect_drain;
  endtask

  task automatic rd1(input logic [AW-1:0] a, input string tag);
    addr = a; strb_proc = 1;
    tick;
    strb_proc = 0;
    tick; tick;
    chk(rvalid && rdata == exp_mem[a], tag, rdata, exp_mem[a]);
    deselect_drain;
  endtask

  task automatic t_reset;
    rst = 1; idle;
    repeat (3) tick;
    rst = 0;
    tick;
    chk(!rvalid && rdata == '0, "R1 reset output", {35'd0, rvalid}, '0);
  endtask

  task automatic t_prefill;
    for (int a = 'h100; a < 'h108; a++) begin
      addr = AW'(a); wdata = pat(AW'(a), 8'h3c); strb_ctrl = 1; all_we = 1;
      exp_mem[a] = pat(AW'(a), 8'h3c);
      tick;
    end
    strb_ctrl = 0; all_we = 0;
    deselect_drain;
    rd1(10'h100, "R12 ctrl write readback");
  endtask

  task automatic t_burst(input logic [AW-1:0] s, input logic ilv, input string tag);
    logic [AW-1:0] ea;
    addr = s; burst_ilv = ilv; strb_proc = 1;
    tick;
    strb_proc = 0; adv = 1; addr = ~s;
    chk(!rvalid, "R6 no data after E0", {35'd0, rvalid}, '0);
    tick;
    chk(!rvalid, "R6 no data after E1", {35'd0, rvalid}, '0);
    for (int k = 0; k < 4; k++) begin
      tick;
      if (k == 1) adv = 0;
      ea = {s[AW-1:2], ilv ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k))};
      chk(rvalid && rdata == exp_mem[ea], tag, rdata, exp_mem[ea]);
    end
    deselect_drain;
  endtask

  task automatic t_oe_hold;
    addr = 10'h106; strb_proc = 1;
    tick;
    strb_proc = 0;
    tick; tick;
    oe = 0; #1;
    chk(!rvalid && rdata == '0, "R7 oe low blanks output", rdata, '0);
    oe = 1; #1;
    chk(rvalid && rdata == exp_mem[10'h106], "R7 oe restore", rdata, exp_mem[10'h106]);
    for (int i = 0; i < 3; i++) begin
      addr = 10'h101 + AW'(i);
      tick;
    end
    chk(rvalid && rdata == exp_mem[10'h106], "R2 R3 addr ignored without strobe/adv",
        rdata, exp_mem[10'h106]);
    deselect_drain;
  endtask

  task automatic t_deselect;
    addr = 10'h102; strb_proc = 1;
    tick;
    strb_proc = 0;
    tick; tick;
    strb_proc = 1; chip_en0 = 0;
    tick;
    strb_proc = 0; chip_en0 = 1;
    chk(rvalid, "R11 valid after Ed", {35'd0, rvalid}, 36'd1);
    tick;
    chk(rvalid && rdata == exp_mem[10'h102], "R11 valid after Ed+1", rdata, exp_mem[10'h102]);
    tick;
    chk(!rvalid, "R11 idle after Ed+2", {35'd0, rvalid}, '0);
    tick;
  endtask

  task automatic t_chip_sel;
    chip_dis2 = 1;
    wr1(10'h100, 36'h0_dead_beef, 1, 0, 4'h0);
    chip_dis2 = 0;
    chip_en1 = 0;
    addr = 10'h100; strb_proc = 1;
    tick;
    strb_proc = 0;
    tick; tick;
    chk(!rvalid, "R8 no read when unselected", {35'd0, rvalid}, '0);
    chip_en1 = 1;
    tick;
    rd1(10'h100, "R8 write blocked by chip enable");
  endtask

  task automatic t_writes;
    logic [DW-1:0] nd;
    nd = 36'h9_1234_5678;
    wr1(10'h103, nd, 1, 0, 4'h0);
    exp_mem[10'h103] = nd;
    rd1(10'h103, "R9 global write all lanes");
    nd = 36'hA_BCDE_F012;
    wr1(10'h104, nd, 0, 1, 4'b0101);
    exp_mem[10'h104][8:0]   = nd[8:0];
    exp_mem[10'h104][26:18] = nd[26:18];
    rd1(10'h104, "R10 lane merge 0101");
    wr1(10'h104, 36'h0, 0, 0, 4'b1111);
    rd1(10'h104, "R10 unqualified lanes do not write");
    addr = 10'h105; wdata = 36'h0; all_we = 1; strb_proc = 1;
    tick;
    strb_proc = 0; all_we = 0;
    deselect_drain;
    rd1(10'h105, "R12 proc strobe ignores write");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_prefill;
    t_burst(10'h101, 1'b0, "R4 linear start 1");
    t_burst(10'h107, 1'b0, "R4 linear start 3");
    t_burst(10'h101, 1'b1, "R5 xor start 1");
    t_burst(10'h107, 1'b1, "R5 xor start 3");
    t_oe_hold;
    t_deselect;
    t_chip_sel;
    t_writes;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule